// File: doc/BRIEF.md
# Vector Floating Compare Mask Writer

This block runs an elementwise floating-point comparison over a vector and writes the result of each comparison into one bit of a mask register. A start pulse loads the mask register with an initial value and latches the operation: a 3-bit condition code, the operand format, the masked-operation enable and its match value, the vector length and, optionally, a scalar operand. The vector elements then arrive one pair per cycle on `elem_a`/`elem_b`, qualified by `elem_valid`. When the scalar select is set, the latched scalar replaces `elem_a` for every element. A one-cycle `done` pulse follows the last element.

The operands use the 16-bit-word floating layout. Word 0 sits in bits 15:0 and holds the sign in bit 15, followed by the exponent, followed by the top of the fraction. Each later word carries less significant fraction bits. Ordering is by sign and magnitude. The magnitude is the exponent followed by the fraction, reassembled from the words in order from word 0 to word 3. A value with a zero exponent and the sign set is a reserved operand. It is flagged and forces its mask bit to zero, and the operation still runs over every element.

Top module: `vcmp_mask_unit`

## Requirements
- R1: Condition code selects the test of A against B: 0 A>B, 1 A==B, 2 A<B, 4 A<=B, 5 A!=B, 6 A>=B. The addressed mask bit becomes 1 when the test holds and 0 when it does not.
- R2: The format select is 0 for F, 1 for D, 2 for G, and 3 behaves as D. The exponent is bits 14:7 for F and D and bits 14:4 for G, with the sign in bit 15. Magnitude order is exponent, then fraction, taking bits 15:0, 31:16, 47:32 and 63:48 in that order of significance. Among negative values the larger magnitude is the smaller number.
- R3: In F format, bits 63:32 of both operands have no effect on the result.
- R4: Mask bits at indices at or above the vector length keep their loaded value. A vector length of 0 gives a done pulse in the cycle after start and leaves the mask as loaded. A length above 64 is treated as 64.
- R5: When masked operation is enabled, a mask bit whose current value differs from the match value is left unchanged. Only bits equal to the match value receive the comparison result.
- R6: An operand with its sign set and a zero exponent is reserved. It writes 0 to its mask bit (unless R5 skips that bit), sets `rop_flag`, and the remaining elements are still processed.
- R7: An operand with its sign clear and a zero exponent compares as exact zero, whatever its fraction bits are.
- R8: Condition codes 3 and 7 leave the whole mask unchanged, set `cond_err`, and still consume all elements and pulse `done`.
- R9: With scalar select set at start, the scalar latched at start is used as operand A for every element, and `elem_a` is ignored.
- R10: After reset the mask, `busy`, `done` and both flags are 0. Start (accepted only when idle) loads `mask_init` and clears both flags. Each element updates the mask at the clock edge where it is accepted. `done` is high for exactly the one cycle after the edge that accepts the last element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| cond | input | 3 | Condition code |
| fmt | input | 2 | Operand format select |
| moe | input | 1 | Masked-operation enable |
| mtf | input | 1 | Mask match value used when `moe` is set |
| vlen | input | 7 | Vector length |
| scalar_sel | input | 1 | Use the scalar as operand A |
| scalar_val | input | 64 | Scalar operand, latched at start |
| mask_init | input | 64 | Mask value loaded at start |
| elem_valid | input | 1 | Element pair present this cycle |
| elem_a | input | 64 | Operand A element |
| elem_b | input | 64 | Operand B element |
| mask_q | output | 64 | Mask register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rop_flag | output | 1 | A reserved operand was seen in this operation |
| cond_err | output | 1 | A reserved condition code was given |

## Verification
The bench targets the corners where a plausible mistake gives a wrong bit.

- **Word order.** The D and G cases differ only in the least significant word, or they trade a high word against a low one. A design that reassembled the words backwards would invert these results.
- **Exponent field.** One pattern is zero in D but nonzero in G, and its negative twin is reserved in D but an ordinary negative number in G. This exposes a design that uses the wrong exponent field.
- **Sign and zero handling.** Pairs of negative numbers catch unsigned ordering. A zero with nonzero fraction bits catches a design that compares raw bits.
- **Mask control.** The masked-operation case mixes matching and non-matching bits with mixed outcomes, and a non-matching bit whose comparison is true would be overwritten by a design that ignores the match value. The tail bits, the zero length and the reserved codes show any write that escapes its window.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    FMT_F  = 2'd0,
    FMT_D  = 2'd1,
    FMT_G  = 2'd2,
    FMT_DX = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    CC_GT = 3'd0,
    CC_EQ = 3'd1,
    CC_LT = 3'd2,
    CC_R3 = 3'd3,
    CC_LE = 3'd4,
    CC_NE = 3'd5,
    CC_GE = 3'd6,
    CC_R7 = 3'd7
  } cc_e;
endpackage

// File: rtl/vcmp_operand_decode.sv
module vcmp_operand_decode
  import vcmp_pkg::*;
#(
  parameter int ELEM_W = 64
) (
  input  logic [ELEM_W-1:0] raw,
  input  fmt_e              fmt,
  output logic              neg,
  output logic              rsv,
  output logic [ELEM_W-2:0] mag
);
  localparam int WORDS = ELEM_W / WORD_W;

  logic [WORD_W-1:0] wsel [WORDS];
  logic [ELEM_W-2:0] mag_raw;
  logic              exp_zero;
  logic              sgn;

  // F keeps only the first two words; the rest are forced to zero
  for (genvar k = 0; k < WORDS; k++) begin : g_word
    if (k >= 2) begin : g_hi
      assign wsel[k] = (fmt == FMT_F) ? '0 : raw[k*WORD_W +: WORD_W];
    end else begin : g_lo
      assign wsel[k] = raw[k*WORD_W +: WORD_W];
    end
  end

  // word 0 (minus sign) is most significant, later words follow
  always_comb begin
    mag_raw = '0;
    mag_raw[ELEM_W-2 -: WORD_W-1] = wsel[0][WORD_W-2:0];
    for (int k = 1; k < WORDS; k++) begin
      mag_raw[(WORDS-1-k)*WORD_W +: WORD_W] = wsel[k];
    end
  end

  assign sgn      = raw[WORD_W-1];
  assign exp_zero = (fmt == FMT_G) ? (raw[14:4] == '0) : (raw[14:7] == '0);
  assign rsv      = sgn & exp_zero;
  assign neg      = sgn & ~exp_zero;
  assign mag      = exp_zero ? '0 : mag_raw;
endmodule

// File: rtl/vcmp_relation.sv
module vcmp_relation
  import vcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             a_neg,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_neg,
  input  logic [MAG_W-1:0] b_mag,
  input  cc_e              cc,
  output logic             hit,
  output logic             cc_bad
);
  logic eq, gt, lt;

  always_comb begin
    eq = (a_neg == b_neg) && (a_mag == b_mag);
    if (a_neg != b_neg) gt = b_neg;
    else if (a_neg)     gt = a_mag < b_mag;
    else                gt = a_mag > b_mag;
    lt = !eq && !gt;
  end

  always_comb begin
    cc_bad = 1'b0;
    unique case (cc)
      CC_GT:   hit = gt;
      CC_EQ:   hit = eq;
      CC_LT:   hit = lt;
      CC_LE:   hit = lt | eq;
      CC_NE:   hit = !eq;
      CC_GE:   hit = gt | eq;
      default: begin
        hit    = 1'b0;
        cc_bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/vcmp_mask_store.sv
module vcmp_mask_store #(
  parameter int MASK_W = 64,
  localparam int IDX_W = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MASK_W-1:0] load_val,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit,
  output logic [MASK_W-1:0] mask_q
);
  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                               mask_q[i] <= 1'b0;
      else if (load)                         mask_q[i] <= load_val[i];
      else if (wr_en && wr_idx == IDX_W'(i)) mask_q[i] <= wr_bit;
    end
  end

  // R10: a load and an element write never meet at the same edge
  always_ff @(posedge clk) begin
    if (!rst) AST_LOAD_WRITE_EXCL: assert (!(load && wr_en)); // R10
  end
endmodule

// File: rtl/vcmp_mask_unit.sv
module vcmp_mask_unit
  import vcmp_pkg::*;
#(
  parameter int ELEM_W = 64,
  parameter int MASK_W = 64,
  localparam int VL_W  = $clog2(MASK_W + 1),
  localparam int IDX_W = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        cond,
  input  logic [1:0]        fmt,
  input  logic              moe,
  input  logic              mtf,
  input  logic [VL_W-1:0]   vlen,
  input  logic              scalar_sel,
  input  logic [ELEM_W-1:0] scalar_val,
  input  logic [MASK_W-1:0] mask_init,
  input  logic              elem_valid,
  input  logic [ELEM_W-1:0] elem_a,
  input  logic [ELEM_W-1:0] elem_b,
  output logic [MASK_W-1:0] mask_q,
  output logic              busy,
  output logic              done,
  output logic              rop_flag,
  output logic              cond_err
);
  localparam int MAG_W = ELEM_W - 1;

  // latched operation
  cc_e               cc_q;
  fmt_e              fmt_q;
  logic              moe_q, mtf_q, scal_q;
  logic [ELEM_W-1:0] sval_q;
  logic [VL_W-1:0]   vlen_q;
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q, done_q, rop_q, cerr_q;

  logic              accept, fire, last, skip_moe, wr_en, wr_bit;
  logic              hit, cc_bad, rsv_any;
  logic [VL_W-1:0]   vlen_clamp;
  logic [MASK_W-1:0] tail_keep;

  logic [ELEM_W-1:0] op_raw [2];
  logic              op_neg [2];
  logic              op_rsv [2];
  logic [MAG_W-1:0]  op_mag [2];

  assign op_raw[0] = scal_q ? sval_q : elem_a;
  assign op_raw[1] = elem_b;

  for (genvar s = 0; s < 2; s++) begin : g_dec
    vcmp_operand_decode #(.ELEM_W(ELEM_W)) dec_i (
      .raw (op_raw[s]),
      .fmt (fmt_q),
      .neg (op_neg[s]),
      .rsv (op_rsv[s]),
      .mag (op_mag[s])
    );
  end

  vcmp_relation #(.MAG_W(MAG_W)) rel_i (
    .a_neg  (op_neg[0]),
    .a_mag  (op_mag[0]),
    .b_neg  (op_neg[1]),
    .b_mag  (op_mag[1]),
    .cc     (cc_q),
    .hit    (hit),
    .cc_bad (cc_bad)
  );

  assign rsv_any    = op_rsv[0] | op_rsv[1];
  assign accept     = start && !busy_q;
  assign fire       = busy_q && elem_valid;
  assign last       = (VL_W'(idx_q) + VL_W'(1)) == vlen_q;
  assign vlen_clamp = (vlen > VL_W'(MASK_W)) ? VL_W'(MASK_W) : vlen;
  assign skip_moe   = moe_q && (mask_q[idx_q] != mtf_q);
  assign wr_en      = fire && !cc_bad && !skip_moe;
  assign wr_bit     = rsv_any ? 1'b0 : hit;

  for (genvar i = 0; i < MASK_W; i++) begin : g_tail
    assign tail_keep[i] = (VL_W'(i) >= vlen_q);
  end

  vcmp_mask_store #(.MASK_W(MASK_W)) store_i (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (mask_init),
    .wr_en    (wr_en),
    .wr_idx   (idx_q),
    .wr_bit   (wr_bit),
    .mask_q   (mask_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q   <= CC_GT;
      fmt_q  <= FMT_F;
      moe_q  <= 1'b0;
      mtf_q  <= 1'b0;
      scal_q <= 1'b0;
      sval_q <= '0;
      vlen_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rop_q  <= 1'b0;
      cerr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        cc_q   <= cc_e'(cond);
        fmt_q  <= fmt_e'(fmt);
        moe_q  <= moe;
        mtf_q  <= mtf;
        scal_q <= scalar_sel;
        sval_q <= scalar_val;
        vlen_q <= vlen_clamp;
        idx_q  <= '0;
        rop_q  <= 1'b0;
        cerr_q <= (cond == 3'd3) || (cond == 3'd7);
        busy_q <= (vlen_clamp != '0);
        done_q <= (vlen_clamp == '0);
      end else if (fire) begin
        idx_q <= idx_q + IDX_W'(1);
        if (rsv_any) rop_q <= 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rop_flag = rop_q;
  assign cond_err = cerr_q;

  AST_TAIL_KEPT: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ((mask_q ^ $past(mask_q)) & $past(tail_keep)) == '0); // R4
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (VL_W'(idx_q) < vlen_q)); // R4
  AST_MOE_SKIP: assert property (@(posedge clk) disable iff (rst)
    (fire && skip_moe) |=> mask_q[$past(idx_q)] == $past(mask_q[idx_q])); // R5
  AST_ROP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (fire && rsv_any && !skip_moe && !cc_bad) |=> (!mask_q[$past(idx_q)] && rop_q)); // R6
  AST_RSVD_CC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cerr_q) |=> mask_q == $past(mask_q)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q); // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!rop_q && mask_q == $past(mask_init))); // R10
endmodule

// File: tb/vcmp_mask_unit_tb_top.sv
`timescale 1ns/1ps
module vcmp_mask_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start, moe, mtf, scalar_sel, elem_valid;
  logic [2:0]  cond;
  logic [1:0]  fmt;
  logic [6:0]  vlen;
  logic [63:0] scalar_val, mask_init, elem_a, elem_b;
  logic [63:0] mask_q;
  logic        busy, done, rop_flag, cond_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic done_seen;
  logic [63:0] ea [8];
  logic [63:0] eb [8];

  always #4 clk = ~clk;

  vcmp_mask_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .cond(cond), .fmt(fmt), .moe(moe),
    .mtf(mtf), .vlen(vlen), .scalar_sel(scalar_sel), .scalar_val(scalar_val),
    .mask_init(mask_init), .elem_valid(elem_valid), .elem_a(elem_a),
    .elem_b(elem_b), .mask_q(mask_q), .busy(busy), .done(done),
    .rop_flag(rop_flag), .cond_err(cond_err)
  );

  typedef struct packed {
    logic [2:0]  c;
    logic [1:0]  f;
    logic [63:0] a;
    logic [63:0] b;
    logic        e;
    logic        r;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 2'd0, 64'h0000_0000_0000_4080, 64'h0000_0000_0000_4000, 1'b1, 1'b0}, // R1 gt
    '{3'd0, 2'd0, 64'h0000_0000_0000_4000, 64'h0000_0000_0000_4080, 1'b0, 1'b0}, // R1 gt false
    '{3'd1, 2'd0, 64'h0000_0000_0000_4080, 64'h0000_0000_0000_4080, 1'b1, 1'b0}, // R1 eq
    '{3'd2, 2'd0, 64'h0000_0000_0000_C100, 64'h0000_0000_0000_C080, 1'b1, 1'b0}, // R2 -2 < -1
    '{3'd4, 2'd0, 64'h0000_0000_0000_4080, 64'h0000_0000_0000_4080, 1'b1, 1'b0}, // R1 le
    '{3'd5, 2'd0, 64'h0000_0000_0000_4080, 64'h0000_0000_0000_4080, 1'b0, 1'b0}, // R1 ne
    '{3'd6, 2'd0, 64'h0000_0000_0000_C080, 64'h0000_0000_0000_4000, 1'b0, 1'b0}, // R1 ge
    '{3'd1, 2'd0, 64'h1234_5678_0000_4080, 64'h0000_0000_0000_4080, 1'b1, 1'b0}, // R3
    '{3'd1, 2'd0, 64'h0000_0000_ABCD_0055, 64'h0000_0000_0000_0000, 1'b1, 1'b0}, // R7
    '{3'd0, 2'd1, 64'h0002_0000_0000_4080, 64'h0001_0000_0000_4080, 1'b1, 1'b0}, // R2 low word
    '{3'd2, 2'd1, 64'h0000_0000_0001_4080, 64'hFFFF_0000_0000_4080, 1'b0, 1'b0}, // R2 word order
    '{3'd0, 2'd2, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0000, 1'b1, 1'b0}, // R2 G exponent
    '{3'd0, 2'd1, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0000, 1'b0, 1'b0}, // R7 D zero
    '{3'd2, 2'd2, 64'h0000_0000_0000_8010, 64'h0000_0000_0000_0000, 1'b1, 1'b0}, // R2 G negative
    '{3'd5, 2'd2, 64'h0000_0000_0000_4010, 64'h0000_0000_0000_C010, 1'b1, 1'b0}, // R1 ne G
    '{3'd0, 2'd0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_C080, 1'b1, 1'b0}, // R2 0 > -1
    '{3'd1, 2'd0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_0000, 1'b0, 1'b1}, // R6 rop in A
    '{3'd6, 2'd0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_8055, 1'b0, 1'b1}, // R6 rop in B
    '{3'd0, 2'd3, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0000, 1'b0, 1'b0}  // R2 fmt 3 as D
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] c, input logic [1:0] f, input logic m,
                        input logic t, input logic [6:0] n, input logic s,
                        input logic [63:0] sv, input logic [63:0] mi);
    @(negedge clk);
    start = 1'b1; cond = c; fmt = f; moe = m; mtf = t; vlen = n;
    scalar_sel = s; scalar_val = sv; mask_init = mi;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < int'(n); i++) begin
      elem_valid = 1'b1; elem_a = ea[i]; elem_b = eb[i];
      @(negedge clk);
    end
    elem_valid = 1'b0;
    done_seen = done;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; cond = '0; fmt = '0; moe = 1'b0; mtf = 1'b0;
    vlen = '0; scalar_sel = 1'b0; scalar_val = '0; mask_init = '0;
    elem_valid = 1'b0; elem_a = '0; elem_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset mask", mask_q, 64'h0);
    check("R10 reset status", {60'h0, busy, done, rop_flag, cond_err}, 64'h0);

    // table walk: one element per operation, bit 0 preset to the opposite value
    for (int k = 0; k < NV; k++) begin
      ea[0] = TBL[k].a; eb[0] = TBL[k].b;
      run_op(TBL[k].c, TBL[k].f, 1'b0, 1'b0, 7'd1, 1'b0, 64'h0,
             {63'h52D2_52D2_52D2_52D2, ~TBL[k].e});
      check($sformatf("R1/R2 table %0d mask", k), mask_q,
            {63'h52D2_52D2_52D2_52D2, TBL[k].e});
      check($sformatf("R6 table %0d rop", k), {63'h0, rop_flag}, {63'h0, TBL[k].r});
    end

    // R4/R10: five elements, tail untouched, done right after the last one
    ea[0] = 64'h4080; eb[0] = 64'h4080;
    ea[1] = 64'h4080; eb[1] = 64'h4000;
    ea[2] = 64'h4000; eb[2] = 64'h4000;
    ea[3] = 64'hC080; eb[3] = 64'h4080;
    ea[4] = 64'h0000; eb[4] = 64'h0077;
    run_op(3'd1, 2'd0, 1'b0, 1'b0, 7'd5, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R4 five-element mask", mask_q, 64'hFFFF_FFFF_FFFF_FFF5);
    check("R10 done pulse", {63'h0, done_seen}, 64'h1);
    @(negedge clk);
    check("R10 done one cycle", {62'h0, done, busy}, 64'h0);

    // R4: zero length
    run_op(3'd1, 2'd0, 1'b0, 1'b0, 7'd0, 1'b0, 64'h0, 64'h0123_4567_89AB_CDEF);
    check("R4 zero length done", {63'h0, done_seen}, 64'h1);
    check("R4 zero length mask", mask_q, 64'h0123_4567_89AB_CDEF);

    // R5: masked operation, match value 1, results F T T F
    ea[0] = 64'h4000; eb[0] = 64'h4080;
    ea[1] = 64'h4080; eb[1] = 64'h4000;
    ea[2] = 64'h4080; eb[2] = 64'h4000;
    ea[3] = 64'h4000; eb[3] = 64'h4080;
    run_op(3'd0, 2'd0, 1'b1, 1'b1, 7'd4, 1'b0, 64'h0, 64'hF0F0_0000_0000_0005);
    check("R5 masked operation", mask_q, 64'hF0F0_0000_0000_0004);

    // R8: reserved condition code
    ea[0] = 64'h4080; eb[0] = 64'h4080;
    ea[1] = 64'h4000; eb[1] = 64'h4080;
    ea[2] = 64'h8000; eb[2] = 64'h0000;
    run_op(3'd3, 2'd0, 1'b0, 1'b0, 7'd3, 1'b0, 64'h0, 64'hAAAA_5555_AAAA_5555);
    check("R8 code 3 mask", mask_q, 64'hAAAA_5555_AAAA_5555);
    check("R8 code 3 err/done", {62'h0, cond_err, done_seen}, 64'h3);
    run_op(3'd7, 2'd0, 1'b0, 1'b0, 7'd3, 1'b0, 64'h0, 64'h0000_0000_0000_0002);
    check("R8 code 7 mask", mask_q, 64'h0000_0000_0000_0002);

    // R9: scalar 1.0 > B, elem_a carries a large value that must be ignored
    ea[0] = 64'h7FFF; eb[0] = 64'h4000;
    ea[1] = 64'h7FFF; eb[1] = 64'h4080;
    ea[2] = 64'h7FFF; eb[2] = 64'h4100;
    run_op(3'd0, 2'd0, 1'b0, 1'b0, 7'd3, 1'b1, 64'h0000_0000_0000_4080, 64'h0);
    check("R9 scalar broadcast", mask_q, 64'h1);
    check("R10 flags cleared at start", {62'h0, cond_err, rop_flag}, 64'h0);

    // R6: reserved operand mid-vector, all elements still processed
    ea[0] = 64'h4080; eb[0] = 64'h4080;
    ea[1] = 64'h8000; eb[1] = 64'h8000;
    ea[2] = 64'h4000; eb[2] = 64'h4000;
    run_op(3'd1, 2'd0, 1'b0, 1'b0, 7'd3, 1'b0, 64'h0, 64'h2);
    check("R6 mid-vector rop mask", mask_q, 64'h5);
    check("R6 rop flag and done", {62'h0, rop_flag, done_seen}, 64'h3);

    // R4: length above 64 is clamped; vector of 64 equal pairs, start from zero
    for (int i = 0; i < 8; i++) begin ea[i] = 64'h4080; eb[i] = 64'h4080; end
    @(negedge clk);
    start = 1'b1; cond = 3'd1; fmt = 2'd0; moe = 1'b0; vlen = 7'd100;
    scalar_sel = 1'b0; mask_init = 64'h0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 64; i++) begin
      elem_valid = 1'b1; elem_a = 64'h4080; elem_b = 64'h4080;
      @(negedge clk);
    end
    elem_valid = 1'b0;
    check("R4 clamp done", {62'h0, done, busy}, 64'h2);
    check("R4 clamp mask", mask_q, 64'hFFFF_FFFF_FFFF_FFFF);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule